// File: doc/BRIEF.md
# Drowsy Cache Line Controller

This block tracks which lines of a small set-associative cache sit in a low-voltage retention state. One free-running interval counter is shared by the whole cache. Each time it expires, every line is marked drowsy in the same cycle. There are no per-line timers. A drowsy line keeps its contents; it only has to be raised back to full voltage before it can be used.

A lookup names a set and a way. If the target line is awake, the request completes in the same cycle. If it is drowsy, the controller holds `reqReady` low for exactly one cycle, pulses `wakePulse` and wakes that line. The requester keeps the request up and it completes on the following cycle. The per-line drowsy vector is exported so that an error-rate model or a power monitor can see which lines are in the retention state at any time. The data array, the tag compare and the voltage rails lie outside this block.

Top module: `drowsy_line_ctrl`

## Requirements
- R1: During and after reset, every line is awake: `drowsyVec` is all zeros, `wakePulse` is low and `reqReady` is high.
- R2: The interval counter starts at zero when reset is released. It raises an internal sweep in the cycle before every INTERVAL-th rising edge. With INTERVAL=40 the lines become drowsy at edges 40, 80, 120 and so on after release, and `drowsyVec` is still all zeros in the cycle before edge 40.
- R3: A sweep sets every bit of `drowsyVec` at the same edge, whatever state each line was in.
- R4: A request to an awake line is accepted in the same cycle (`reqReady` high, `wakePulse` low) and leaves `drowsyVec` unchanged.
- R5: A request to a drowsy line drives `reqReady` low and `wakePulse` high for one cycle, and clears that line's bit at the next edge. When the request is held, it is accepted on the next cycle with no further pulse.
- R6: Line (set s, way w) maps to bit s*NUM_WAYS+w of `drowsyVec`. A wake clears only that bit.
- R7: If a wake and a sweep fall on the same edge, the sweep wins and the line stays drowsy. A held request then stalls once more, wakes the line at the next edge and is accepted one cycle later.
- R8: The interval counter keeps running through stall cycles, so stalls do not move the sweep edges.
- R9: A drowsy bit is set only by a sweep. No request and no idle period can set one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A lookup request is present |
| reqSet | input | $clog2(NUM_SETS) | Set index of the request |
| reqWay | input | $clog2(NUM_WAYS) | Way index of the request |
| reqReady | output | 1 | The request is accepted in this cycle; low while the target line wakes |
| drowsyVec | output | NUM_SETS*NUM_WAYS | Per-line drowsy state, bit set*NUM_WAYS+way |
| wakePulse | output | 1 | High in each wake-up penalty cycle |

## Verification
The assertions assume that `reqSet` is below NUM_SETS and that a requester held off by a low `reqReady` keeps the same set and way until the request is accepted. The one-cycle-penalty property only checks a held request. The stimulus only uses legal set indices. Every stalled request is repeated unchanged on the next cycle, and that includes the request placed on a sweep edge, which stalls twice.

// File: rtl/drowsy_pkg.sv
package drowsy_pkg;

  // Strobes from the control half to the state array
  typedef struct packed {
    logic sweep;  // put every line to sleep at this edge
    logic wake;   // wake the line named by the index at this edge
  } lineStrobe_t;

endpackage

// File: rtl/drowsy_sweep_ctrl.sv
module drowsy_sweep_ctrl
  import drowsy_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 2,
  parameter int INTERVAL = 4000
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  input  logic [$clog2(NUM_SETS)-1:0]     reqSet,
  input  logic [$clog2(NUM_WAYS)-1:0]     reqWay,
  input  logic [NUM_SETS*NUM_WAYS-1:0]    drowsyVec,
  output lineStrobe_t                     strb,
  output logic [$clog2(NUM_SETS*NUM_WAYS)-1:0] lineIdx,
  output logic                            reqReady,
  output logic                            wakePulse
);

  localparam int LINES   = NUM_SETS * NUM_WAYS;
  localparam int LINE_W  = $clog2(LINES);
  localparam int COUNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [COUNT_W-1:0] LAST = COUNT_W'(INTERVAL - 1);

  logic [COUNT_W-1:0] intervalCount;
  logic               sweepNow;
  logic               hitDrowsy;

  // Shared interval counter, never paused by stalls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCount <= '0;
    end else if (intervalCount == LAST) begin
      intervalCount <= '0;
    end else begin
      intervalCount <= intervalCount + 1'b1;
    end
  end

  assign sweepNow = (intervalCount == LAST);

  always_comb begin
    lineIdx   = LINE_W'(reqSet) * LINE_W'(NUM_WAYS) + LINE_W'(reqWay);
    hitDrowsy = reqValid && drowsyVec[lineIdx];
    reqReady  = !hitDrowsy;
    wakePulse = hitDrowsy;
    strb.sweep = sweepNow;
    strb.wake  = hitDrowsy;
  end

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    intervalCount <= LAST);

  assert_sweep_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    sweepNow |=> (intervalCount == '0));

  assert_stall_needs_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> reqValid);

  assert_one_cycle_penalty_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wakePulse) && !$past(sweepNow) && reqValid && (lineIdx == $past(lineIdx)))
      |-> reqReady);

endmodule

// File: rtl/drowsy_state_array.sv
module drowsy_state_array
  import drowsy_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lineStrobe_t              strb,
  input  logic [$clog2(LINES)-1:0] wakeIdx,
  output logic [LINES-1:0]         drowsyVec
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        drowsyVec[i] <= 1'b0;
      end else if (strb.sweep) begin
        drowsyVec[i] <= 1'b1;
      end else if (strb.wake && (wakeIdx == i[$clog2(LINES)-1:0])) begin
        drowsyVec[i] <= 1'b0;
      end
    end
  end

  assert_sweep_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.sweep |=> (&drowsyVec));

  assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wake && !strb.sweep) |=> !drowsyVec[$past(wakeIdx)]);

  assert_sweep_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wake && strb.sweep) |=> drowsyVec[$past(wakeIdx)]);

  assert_set_only_by_sweep_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((drowsyVec & ~$past(drowsyVec)) != '0) |-> $past(strb.sweep));

endmodule

// File: rtl/drowsy_line_ctrl.sv
module drowsy_line_ctrl
  import drowsy_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 2,
  parameter int INTERVAL = 4000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [$clog2(NUM_SETS)-1:0]   reqSet,
  input  logic [$clog2(NUM_WAYS)-1:0]   reqWay,
  output logic                          reqReady,
  output logic [NUM_SETS*NUM_WAYS-1:0]  drowsyVec,
  output logic                          wakePulse
);

  localparam int LINES  = NUM_SETS * NUM_WAYS;
  localparam int LINE_W = $clog2(LINES);

  lineStrobe_t       strb;
  logic [LINE_W-1:0] lineIdx;

  drowsy_sweep_ctrl #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .INTERVAL (INTERVAL)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqSet    (reqSet),
    .reqWay    (reqWay),
    .drowsyVec (drowsyVec),
    .strb      (strb),
    .lineIdx   (lineIdx),
    .reqReady  (reqReady),
    .wakePulse (wakePulse)
  );

  drowsy_state_array #(
    .LINES (LINES)
  ) state_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wakeIdx   (lineIdx),
    .drowsyVec (drowsyVec)
  );

endmodule

// File: tb/drowsy_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module drowsy_line_ctrl_tb_top;

  localparam int SETS  = 8;
  localparam int WAYS  = 2;
  localparam int IVAL  = 40;
  localparam int LINES = SETS * WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [SET_W-1:0] reqSet = '0;
  logic [WAY_W-1:0] reqWay = '0;
  logic             reqReady;
  logic [LINES-1:0] drowsyVec;
  logic             wakePulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // Expected items, one entry per cycle
  logic             expReadyQ[$];
  logic             expPulseQ[$];
  logic [LINES-1:0] expVecQ[$];
  string            tagQ[$];

  // Bench model of the requirements
  logic [LINES-1:0] refDrowsy = '0;
  int               refCount = 0;

  always #10 clk = ~clk;

  drowsy_line_ctrl #(
    .NUM_SETS (SETS),
    .NUM_WAYS (WAYS),
    .INTERVAL (IVAL)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqSet    (reqSet),
    .reqWay    (reqWay),
    .reqReady  (reqReady),
    .drowsyVec (drowsyVec),
    .wakePulse (wakePulse)
  );

  task automatic step(input logic v, input int s, input int w, input string tag);
    int  idx;
    logic hit;
    @(negedge clk);
    reqValid = v;
    reqSet   = SET_W'(s);
    reqWay   = WAY_W'(w);
    idx = s * WAYS + w;   // R6 line mapping
    hit = v && refDrowsy[idx];
    expReadyQ.push_back(!hit);
    expPulseQ.push_back(hit);
    expVecQ.push_back(refDrowsy);
    tagQ.push_back(tag);
    @(posedge clk);
    if (refCount == IVAL - 1) begin
      refDrowsy = '1;            // R7: sweep wins over a wake
      refCount  = 0;
    end else begin
      if (hit) refDrowsy[idx] = 1'b0;
      refCount++;
    end
    cyc++;
  endtask

  // Monitor: pop and compare once outputs have settled
  always @(negedge clk) begin
    #2;
    if (tagQ.size() > 0) begin
      logic             eR;
      logic             eP;
      logic [LINES-1:0] eV;
      string            t;
      eR = expReadyQ.pop_front();
      eP = expPulseQ.pop_front();
      eV = expVecQ.pop_front();
      t  = tagQ.pop_front();
      checks += 3;
      if (reqReady !== eR) begin
        errors++;
        $display("FAIL %s reqReady actual %b expected %b", t, reqReady, eR);
      end
      if (wakePulse !== eP) begin
        errors++;
        $display("FAIL %s wakePulse actual %b expected %b", t, wakePulse, eP);
      end
      if (drowsyVec !== eV) begin
        errors++;
        $display("FAIL %s drowsyVec actual %h expected %h", t, drowsyVec, eV);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: outputs while reset is held
    #2;
    checks += 3;
    if (drowsyVec !== '0) begin errors++; $display("FAIL R1 drowsyVec actual %h expected 0", drowsyVec); end
    if (reqReady !== 1'b1) begin errors++; $display("FAIL R1 reqReady actual %b expected 1", reqReady); end
    if (wakePulse !== 1'b0) begin errors++; $display("FAIL R1 wakePulse actual %b expected 0", wakePulse); end
    @(posedge clk);
    #5 rstN = 1'b1;

    step(1'b0, 0, 0, "R1");                                    // cycle 0
    for (int i = 1; i <= 5; i++) step(1'b1, i % SETS, i % WAYS, "R4");
    while (cyc < 39) step(1'b0, 0, 0, "R2");
    step(1'b0, 0, 0, "R2");                                    // cycle 39: still awake
    step(1'b1, 3, 1, "R5");                                    // cycle 40: all drowsy, stall
    step(1'b1, 3, 1, "R5");                                    // accepted
    step(1'b1, 5, 0, "R6");
    step(1'b1, 5, 0, "R6");
    for (int k = 0; cyc < 78; k++) begin                       // R8 stalls while counting
      step(1'b1, k % 7, k % 2, "R8");
      step(1'b1, k % 7, k % 2, "R8");
    end
    while (cyc < 79) step(1'b0, 0, 0, "R8");
    step(1'b1, 7, 1, "R7");                                    // cycle 79: wake meets sweep
    step(1'b1, 7, 1, "R7");                                    // cycle 80: stalls again
    step(1'b1, 7, 1, "R7");                                    // cycle 81: accepted
    while (cyc < 118) step(1'b0, 0, 0, "R9");
    while (cyc < 126) step(1'b0, 0, 0, "R3");                  // second sweep at edge 120
    step(1'b1, 2, 0, "R5");
    step(1'b1, 2, 0, "R5");
    step(1'b1, 2, 0, "R4");

    @(negedge clk);
    #5;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule